// File: doc/BRIEF.md
# Floating-Point Error Reporting and Context-Switch Gate

This block sits between an instruction issue stage and the floating-point unit of a processor core. It decides what happens when the floating-point unit reports an unmasked numeric error. A native-mode control input selects between two paths. The first path raises an internal exception request. The second is the legacy external path: it drives an active-low error output towards an external interrupt controller and holds back the next floating-point instruction that waits for errors. A separate active-low ignore input, when asserted, makes the legacy path discard errors.

The block also keeps a task-switched flag. The flag is set on every task switch and cleared only on explicit request. While it is set, any floating-point or SIMD instruction presented at issue is trapped with a device-not-available request and does not execute. This lets the system software defer saving the floating-point context until a new task actually uses the unit. The arithmetic itself is outside the block.

Instruction class encoding on `issue_class_i`: 2'b00 integer or other non-floating-point work, 2'b01 waiting floating-point instruction (arithmetic or WAIT), 2'b10 non-waiting floating-point control instruction, 2'b11 SIMD instruction.

Top module: `fpu_err_gate`

## Requirements
- R1: After a clock edge with `rst_n` low, `fp_err_n_o` is 1, `native_exc_o` is 0, the task-switched flag is clear and no error is pending. An integer issue then fires with `issue_ready_o`=1, `stall_o`=0 and `dna_exc_o`=0.
- R2: An error pulse with `ne_i`=1 drives `native_exc_o` to 1 for exactly the one cycle after the pulse, and leaves `fp_err_n_o` at 1.
- R3: An error pulse with `ne_i`=0 and `ext_ignore_n_i`=0 is ignored. `fp_err_n_o` stays 1 and `native_exc_o` stays 0. A later waiting instruction (class 2'b01) fires even if `ext_ignore_n_i` rises afterwards, because the mode is taken when the error arrives.
- R4: An error pulse with `ne_i`=0 and `ext_ignore_n_i`=1 latches a pending error. `fp_err_n_o` goes to 0 from the cycle after the pulse and stays 0 until an `err_clear_i` pulse. It returns to 1 in the cycle after that pulse.
- R5: While an error is pending, a valid waiting instruction (class 2'b01) is stalled. `stall_o`=1, `issue_ready_o`=0 and `issue_fire_o`=0.
- R6: While an error is pending, valid instructions of class 2'b10, 2'b11 and 2'b00 are not stalled and fire.
- R7: A `task_switch_i` pulse sets the task-switched flag and a `ts_clear_i` pulse clears it. When both occur in the same cycle, the flag ends up set.
- R8: While the task-switched flag is set, a valid instruction of class 2'b01, 2'b10 or 2'b11 gives `dna_exc_o`=1, `issue_ready_o`=1 and `issue_fire_o`=0. A class 2'b00 issue fires with `dna_exc_o`=0.
- R9: When the task-switched flag is set and an error is pending at the same time, a waiting instruction is trapped with `dna_exc_o`=1 and is not stalled (`stall_o`=0).
- R10: An external-mode error pulse and an `err_clear_i` pulse in the same cycle leave the error pending (`fp_err_n_o`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fp_err_i | input | 1 | One-cycle pulse: the floating-point unit reports an unmasked numeric error |
| err_clear_i | input | 1 | One-cycle pulse: clear the latched external error |
| ne_i | input | 1 | 1 selects native (internal exception) error reporting |
| ext_ignore_n_i | input | 1 | Active-low external ignore request for the legacy path |
| issue_valid_i | input | 1 | An instruction is presented at issue |
| issue_class_i | input | 2 | Class of the presented instruction |
| task_switch_i | input | 1 | One-cycle pulse: a task switch happened |
| ts_clear_i | input | 1 | One-cycle pulse: clear the task-switched flag |
| fp_err_n_o | output | 1 | Active-low legacy error output to the interrupt controller |
| issue_ready_o | output | 1 | Issue handshake ready; 0 while stalled |
| issue_fire_o | output | 1 | The presented instruction proceeds to execution |
| stall_o | output | 1 | A waiting instruction is held back by a pending error |
| native_exc_o | output | 1 | Internal numeric-error exception request |
| dna_exc_o | output | 1 | Device-not-available exception request |

## Verification
The hardest situation to reach from the ports is a pending external error and a set task-switched flag at the same moment. Here the trap must win over the stall. The stimulus first latches an error in legacy mode, then pulses a task switch while the error is still held. Only then does it present a waiting instruction. A second awkward case is a change of the ignore input after an error was already discarded. The bench raises the input between the error and the issue, and checks that no stall appears.

// File: rtl/fpe_pkg.sv
// Package: shared instruction-class type for the floating-point error gate.
// Assumes the issue stage tags each instruction with one of four classes.
package fpe_pkg;

    localparam int CLASS_W = 2;

    typedef enum logic [CLASS_W-1:0] {
        CLS_INT     = 2'b00,
        CLS_FP_WAIT = 2'b01,
        CLS_FP_CTRL = 2'b10,
        CLS_SIMD    = 2'b11
    } ins_class_e;

    // True for every class that touches floating-point or SIMD state.
    function automatic logic uses_fp_state(input ins_class_e c);
        return (c != CLS_INT);
    endfunction

    // True for classes that must wait for a pending numeric error.
    function automatic logic waits_for_error(input ins_class_e c);
        return (c == CLS_FP_WAIT);
    endfunction

endpackage

// File: rtl/fpe_ts_tracker.sv
// Module: task-switched flag keeper.
// Sets on a task-switch pulse and clears on an explicit request. A set
// in the same cycle as a clear wins, since the switch is the newer event.
// Assumes both inputs are synchronous single-cycle pulses.
module fpe_ts_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic task_switch_i,
    input  logic ts_clear_i,
    output logic ts_o
);

    logic ts_q;

    // Flag register: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)             ts_q <= 1'b0;
        else if (task_switch_i) ts_q <= 1'b1;
        else if (ts_clear_i)    ts_q <= 1'b0;
    end

    assign ts_o = ts_q;

    // R7
    ts_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        task_switch_i |=> ts_q);

    // R7
    ts_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_clear_i && !task_switch_i) |=> !ts_q);

endmodule

// File: rtl/fpe_err_latch.sv
// Module: numeric error router and latch.
// Routes an unmasked error pulse by the mode in force in that cycle:
// native mode gives a one-cycle exception request, legacy mode with the
// ignore input high latches a pending error, and legacy mode with the
// ignore input low drops the error. A new error beats a same-cycle clear.
// Assumes fp_err_i is a single-cycle pulse per error.
module fpe_err_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic err_i,
    input  logic clear_i,
    input  logic ne_i,
    input  logic ignore_n_i,
    output logic pend_o,
    output logic native_o
);

    logic pend_q;
    logic native_q;
    logic legacy_take;
    logic native_take;

    // Classify the incoming error by the current mode inputs.
    always_comb begin
        native_take = err_i && ne_i;
        legacy_take = err_i && !ne_i && ignore_n_i;
    end

    // Pending-error latch: a new error has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)           pend_q <= 1'b0;
        else if (legacy_take) pend_q <= 1'b1;
        else if (clear_i)     pend_q <= 1'b0;
    end

    // Native exception request: registered one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) native_q <= 1'b0;
        else        native_q <= native_take;
    end

    assign pend_o   = pend_q;
    assign native_o = native_q;

    // R4
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !clear_i) |=> pend_q);

    // R10
    set_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_i && !ne_i && ignore_n_i && clear_i) |=> pend_q);

    // R2
    native_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_i && ne_i) |=> native_q);

    // R3
    ignored_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_i && !ne_i && !ignore_n_i && !pend_q) |=> (!pend_q && !native_q));

endmodule

// File: rtl/fpe_issue_gate.sv
// Module: issue-time gating of floating-point work.
// Traps any floating-point or SIMD issue while the task-switched flag is
// set. Otherwise it holds waiting instructions while an external error is
// pending. The trap wins over the stall, and a trapped instruction is
// consumed without executing. Purely combinational; the clock and reset
// are used only by the assertions.
module fpe_issue_gate
    import fpe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       valid_i,
    input  ins_class_e class_i,
    input  logic       ts_i,
    input  logic       pend_i,
    output logic       ready_o,
    output logic       fire_o,
    output logic       stall_o,
    output logic       dna_o
);

    logic trap;
    logic hold;

    // Decide trap, stall and execution for the presented instruction.
    always_comb begin
        trap    = valid_i && ts_i && uses_fp_state(class_i);
        hold    = valid_i && !trap && pend_i && waits_for_error(class_i);
        stall_o = hold;
        ready_o = !hold;
        dna_o   = trap;
        fire_o  = valid_i && !hold && !trap;
    end

    // R5
    stall_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> (!fire_o && !ready_o));

    // R8
    trap_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dna_o |-> (!fire_o && ready_o));

    // R9
    trap_over_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && ts_i && pend_i) |-> !stall_o);

    // R6
    nonwait_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !ts_i && class_i != CLS_FP_WAIT) |-> fire_o);

endmodule

// File: rtl/fpu_err_gate.sv
// Module: top of the floating-point error reporting and gating block.
// Joins the error latch, the task-switched flag and the issue gate, and
// turns the internal pending state into the active-low legacy error line.
// Assumes all inputs are synchronous to clk.
module fpu_err_gate (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fp_err_i,
    input  logic       err_clear_i,
    input  logic       ne_i,
    input  logic       ext_ignore_n_i,
    input  logic       issue_valid_i,
    input  logic [1:0] issue_class_i,
    input  logic       task_switch_i,
    input  logic       ts_clear_i,
    output logic       fp_err_n_o,
    output logic       issue_ready_o,
    output logic       issue_fire_o,
    output logic       stall_o,
    output logic       native_exc_o,
    output logic       dna_exc_o
);
    import fpe_pkg::*;

    logic       pend;
    logic       ts;
    ins_class_e cls;

    assign cls = ins_class_e'(issue_class_i);

    fpe_err_latch u_err (
        .clk        (clk),
        .rst_n      (rst_n),
        .err_i      (fp_err_i),
        .clear_i    (err_clear_i),
        .ne_i       (ne_i),
        .ignore_n_i (ext_ignore_n_i),
        .pend_o     (pend),
        .native_o   (native_exc_o)
    );

    fpe_ts_tracker u_ts (
        .clk           (clk),
        .rst_n         (rst_n),
        .task_switch_i (task_switch_i),
        .ts_clear_i    (ts_clear_i),
        .ts_o          (ts)
    );

    fpe_issue_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (issue_valid_i),
        .class_i (cls),
        .ts_i    (ts),
        .pend_i  (pend),
        .ready_o (issue_ready_o),
        .fire_o  (issue_fire_o),
        .stall_o (stall_o),
        .dna_o   (dna_exc_o)
    );

    // Legacy error line: low while an external error is pending.
    assign fp_err_n_o = !pend;

    // R1
    err_line_reset_chk: assert property (@(posedge clk)
        !rst_n |=> fp_err_n_o);

    // R2
    native_no_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_err_i && ne_i && fp_err_n_o && !err_clear_i) |=> fp_err_n_o);

endmodule

// File: tb/fpu_err_gate_tb.sv
module fpu_err_gate_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       fp_err_i, err_clear_i, ne_i, ext_ignore_n_i;
    logic       issue_valid_i;
    logic [1:0] issue_class_i;
    logic       task_switch_i, ts_clear_i;
    logic       fp_err_n_o, issue_ready_o, issue_fire_o, stall_o;
    logic       native_exc_o, dna_exc_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    fpu_err_gate u_dut (
        .clk(clk), .rst_n(rst_n), .fp_err_i(fp_err_i), .err_clear_i(err_clear_i),
        .ne_i(ne_i), .ext_ignore_n_i(ext_ignore_n_i), .issue_valid_i(issue_valid_i),
        .issue_class_i(issue_class_i), .task_switch_i(task_switch_i),
        .ts_clear_i(ts_clear_i), .fp_err_n_o(fp_err_n_o), .issue_ready_o(issue_ready_o),
        .issue_fire_o(issue_fire_o), .stall_o(stall_o), .native_exc_o(native_exc_o),
        .dna_exc_o(dna_exc_o)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic issue(input logic [1:0] c);
        issue_valid_i = 1'b1;
        issue_class_i = c;
        settle();
    endtask

    task automatic idle();
        issue_valid_i = 1'b0;
        issue_class_i = 2'b00;
    endtask

    task automatic pulse_err();
        fp_err_i = 1'b1; tick(); fp_err_i = 1'b0; settle();
    endtask

    task automatic t_reset();
        rst_n = 1'b0; repeat (3) tick(); rst_n = 1'b1; settle();
        check("R1 err line", fp_err_n_o, 1'b1);
        check("R1 native", native_exc_o, 1'b0);
        issue(2'b00);
        check("R1 int fire", issue_fire_o, 1'b1);
        check("R1 ready", issue_ready_o, 1'b1);
        check("R1 stall", stall_o, 1'b0);
        issue(2'b01);
        check("R1 no ts trap", dna_exc_o, 1'b0);
        idle();
    endtask

    task automatic t_native();
        ne_i = 1'b1; ext_ignore_n_i = 1'b1;
        pulse_err();
        check("R2 native pulse", native_exc_o, 1'b1);
        check("R2 line untouched", fp_err_n_o, 1'b1);
        tick(); settle();
        check("R2 single cycle", native_exc_o, 1'b0);
        ne_i = 1'b0;
    endtask

    task automatic t_ignore();
        ne_i = 1'b0; ext_ignore_n_i = 1'b0;
        pulse_err();
        check("R3 line high", fp_err_n_o, 1'b1);
        check("R3 no native", native_exc_o, 1'b0);
        ext_ignore_n_i = 1'b1;
        issue(2'b01);
        check("R3 wait fires", issue_fire_o, 1'b1);
        check("R3 no stall", stall_o, 1'b0);
        idle();
    endtask

    task automatic t_external();
        ne_i = 1'b0; ext_ignore_n_i = 1'b1;
        pulse_err();
        check("R4 line low", fp_err_n_o, 1'b0);
        issue(2'b01);
        check("R5 stall", stall_o, 1'b1);
        check("R5 not ready", issue_ready_o, 1'b0);
        check("R5 no fire", issue_fire_o, 1'b0);
        repeat (3) tick(); settle();
        check("R4 line held", fp_err_n_o, 1'b0);
        check("R5 still stalled", stall_o, 1'b1);
        issue(2'b10);
        check("R6 ctrl fires", issue_fire_o, 1'b1);
        check("R6 ctrl no stall", stall_o, 1'b0);
        issue(2'b11);
        check("R6 simd fires", issue_fire_o, 1'b1);
        issue(2'b00);
        check("R6 int fires", issue_fire_o, 1'b1);
        issue(2'b01);
        err_clear_i = 1'b1; tick(); err_clear_i = 1'b0; settle();
        check("R4 line released", fp_err_n_o, 1'b1);
        check("R5 stall released", stall_o, 1'b0);
        check("R5 wait fires", issue_fire_o, 1'b1);
        idle();
    endtask

    task automatic t_ts();
        task_switch_i = 1'b1; tick(); task_switch_i = 1'b0;
        issue(2'b01);
        check("R8 wait trap", dna_exc_o, 1'b1);
        check("R8 wait no fire", issue_fire_o, 1'b0);
        check("R8 ready", issue_ready_o, 1'b1);
        issue(2'b10);
        check("R8 ctrl trap", dna_exc_o, 1'b1);
        issue(2'b11);
        check("R8 simd trap", dna_exc_o, 1'b1);
        issue(2'b00);
        check("R8 int no trap", dna_exc_o, 1'b0);
        check("R8 int fires", issue_fire_o, 1'b1);
        ts_clear_i = 1'b1; tick(); ts_clear_i = 1'b0;
        issue(2'b01);
        check("R7 cleared", dna_exc_o, 1'b0);
        check("R7 fires after clear", issue_fire_o, 1'b1);
        task_switch_i = 1'b1; ts_clear_i = 1'b1; tick();
        task_switch_i = 1'b0; ts_clear_i = 1'b0; settle();
        check("R7 set wins", dna_exc_o, 1'b1);
        ts_clear_i = 1'b1; tick(); ts_clear_i = 1'b0; settle();
        idle();
    endtask

    task automatic t_prio();
        ne_i = 1'b0; ext_ignore_n_i = 1'b1;
        pulse_err();
        task_switch_i = 1'b1; tick(); task_switch_i = 1'b0;
        issue(2'b01);
        check("R9 trap", dna_exc_o, 1'b1);
        check("R9 no stall", stall_o, 1'b0);
        check("R9 no fire", issue_fire_o, 1'b0);
        idle();
        ts_clear_i = 1'b1; err_clear_i = 1'b1; tick();
        ts_clear_i = 1'b0; err_clear_i = 1'b0; settle();
    endtask

    task automatic t_same_cycle();
        ne_i = 1'b0; ext_ignore_n_i = 1'b1;
        fp_err_i = 1'b1; err_clear_i = 1'b1; tick();
        fp_err_i = 1'b0; err_clear_i = 1'b0; settle();
        check("R10 error wins", fp_err_n_o, 1'b0);
        err_clear_i = 1'b1; tick(); err_clear_i = 1'b0; settle();
        check("R10 then clear", fp_err_n_o, 1'b1);
    endtask

    initial begin
        rst_n = 1'b0; fp_err_i = 1'b0; err_clear_i = 1'b0; ne_i = 1'b0;
        ext_ignore_n_i = 1'b1; issue_valid_i = 1'b0; issue_class_i = 2'b00;
        task_switch_i = 1'b0; ts_clear_i = 1'b0;
        tick();
        t_reset();
        t_native();
        t_ignore();
        t_external();
        t_ts();
        t_prio();
        t_same_cycle();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule